// File: doc/BRIEF.md
# Configuration-Space Base Address Register Logic

This block holds the 64-dword configuration space of one function and applies the special write rules for its six base address registers and its expansion-ROM base register. Software writes 8-, 16- or 32-bit values at a byte offset. The block merges the data into the addressed byte lanes, or it replaces the access with the value the register rules demand. A read port returns any dword as it is currently stored.

Each base register slot is set at build time to one of three kinds: absent, memory or I/O. Each present slot has a power-of-two decode size and a reset base. A 32-bit write of all ones in the address bits is a size probe, and the register then answers with its size mask. Memory registers cannot be relocated and fall back to their reset base on any other 32-bit write. I/O registers accept a new base, and each 32-bit write to one also reports a relocation pulse carrying the previous and the new 16-bit port base. The ROM register answers a probe with its negated size, and any other 32-bit write leaves it at a fixed base. The port remapping itself is done elsewhere and is driven by the relocation pulse.

Top module: `cfg_bar_space`

## Requirements
- R1: After reset, a present base register slot reads its reset base and an absent slot reads zero. The ROM dword (index 12, offset 0x30) reads the ROM base when a ROM exists and zero otherwise. All other dwords read zero.
- R2: A write of size code 0 (byte) merges data[7:0] into lane offset[1:0] of dword offset[7:2]. Size code 1 (16-bit) merges data[15:0] into lanes 0-1 or lanes 2-3, chosen by offset[1]. Size code 2 (32-bit) replaces the whole dword. These rules apply wherever R4-R11 do not, and rd_dw returns the stored dword in the cycle after the write.
- R3: A 16-bit write with offset[0]=1, a 32-bit write with offset[1:0]≠0, and any write with size code 3 change nothing.
- R4: The base registers occupy offsets 0x10-0x27, and slot n is at offset 0x10+4n. A 32-bit write there is a size probe when (data | 3 | (size−1)) equals 0xFFFFFFFF. After a probe the register reads ~(size−1) with bit 0 set for I/O and clear for memory.
- R5: A 32-bit write to a memory slot that is not a probe restores the slot's reset base.
- R6: A 32-bit write to an I/O slot that is not a probe stores data with bit 0 forced to 1. In the next cycle mv_valid is high, mv_old holds the previous low 16 bits with bit 0 cleared, and mv_new holds the new low 16 bits with bit 0 cleared.
- R7: A size probe of an I/O slot also raises mv_valid. mv_new is then (~(size−1)) low 16 bits with bit 0 cleared.
- R8: A 32-bit write to an absent slot leaves that dword reading zero.
- R9: 16-bit writes at offsets 0x10-0x2B change nothing.
- R10: A 32-bit write at offset 0x30 makes the ROM dword read −ROM_SIZE when a ROM exists and (data | 0x7FF) equals 0xFFFFFFFF. Any other 32-bit write there makes it read the ROM base, or zero when there is no ROM.
- R11: A 32-bit write at offset 0x04 changes nothing. Byte and 16-bit writes there follow R2.
- R12: mv_valid is high for exactly one cycle after each 32-bit write to a present I/O slot, and it is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit, 3 invalid |
| wr_off | input | 8 | Byte offset in configuration space |
| wr_data | input | 32 | Write data, right-aligned to the access |
| rd_dw | input | 6 | Dword index to read |
| rd_data | output | 32 | Stored value of dword rd_dw |
| mv_valid | output | 1 | I/O base relocation pulse |
| mv_old | output | 16 | Port base before the move |
| mv_new | output | 16 | Port base after the move |

## Verification
A relocation pulse always falls in the cycle that follows its write, so the pulse can coincide with the next configuration write, and even with a second relocation. The bench writes two different I/O slots back to back, and then probes and re-bases one slot in consecutive cycles. On every clock the cycle model checks that each pulse carries the old and new base of the write one cycle earlier. The read port is steered to the dword just written, so the same comparison also shows that the pulse and the stored value describe the same write.

// File: rtl/cfgbar_pkg.sv
package cfgbar_pkg;
   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_HALF = 2'd1,
      ACC_WORD = 2'd2,
      ACC_NONE = 2'd3
   } acc_e;

   localparam int          NUM_BARS     = 6;
   localparam int          SPACE_DWORDS = 64;
   localparam logic [5:0]  DW_CMD       = 6'd1;
   localparam logic [5:0]  DW_BAR_FIRST = 6'd4;
   localparam logic [5:0]  DW_HALF_LAST = 6'd10;
   localparam logic [5:0]  DW_ROM       = 6'd12;

   function automatic bit is_pow2(input logic [31:0] v);
      return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
   endfunction
endpackage

// File: rtl/cfg_lane_merge.sv
module cfg_lane_merge
   import cfgbar_pkg::*;
(
   input  logic [1:0]  acc,
   input  logic [1:0]  lane,
   input  logic [31:0] data,
   input  logic [31:0] cur,
   output logic        aligned,
   output logic [31:0] merged
);
   localparam int LANES = 4;

   logic [LANES-1:0] be;
   logic [31:0]      shifted;

   always_comb begin
      be      = '0;
      aligned = 1'b0;
      unique case (acc_e'(acc))
         ACC_BYTE: begin
            be      = 4'b0001 << lane;
            aligned = 1'b1;
         end
         ACC_HALF: begin
            be      = lane[1] ? 4'b1100 : 4'b0011;
            aligned = !lane[0];
         end
         ACC_WORD: begin
            be      = 4'b1111;
            aligned = (lane == 2'd0);
         end
         default: begin
            be      = '0;
            aligned = 1'b0;
         end
      endcase
      shifted = data << {lane, 3'b000};
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[8*g +: 8] = be[g] ? shifted[8*g +: 8] : cur[8*g +: 8];
   end
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
   parameter logic [31:0] SIZE    = 32'd16,
   parameter bit          IS_IO   = 1'b0,
   parameter logic [31:0] DEFAULT = 32'd0
) (
   input  logic [31:0] wdata,
   output logic [31:0] nxt
);
   localparam logic [31:0] MASK  = SIZE - 32'd1;
   localparam logic [31:0] PROBE = ~MASK;

   logic probe;
   assign probe = ((wdata | 32'd3 | MASK) == 32'hFFFF_FFFF);

   if (IS_IO) begin : g_io
      if (SIZE < 32'd4 || !cfgbar_pkg::is_pow2(SIZE))
         $error("I/O base register size must be a power of two of at least 4");
      if (!DEFAULT[0])
         $error("I/O base register default must have bit 0 set");
      assign nxt = probe ? (PROBE | 32'd1) : (wdata | 32'd1);
   end else begin : g_mem
      if (SIZE < 32'd16 || !cfgbar_pkg::is_pow2(SIZE))
         $error("memory base register size must be a power of two of at least 16");
      if (DEFAULT[0])
         $error("memory base register default must have bit 0 clear");
      assign nxt = probe ? PROBE : DEFAULT;
   end
endmodule

// File: rtl/cfg_rom_slot.sv
module cfg_rom_slot #(
   parameter logic [31:0] ROM_SIZE = 32'h0000_0800,
   parameter logic [31:0] ROM_ADDR = 32'd0
) (
   input  logic [31:0] wdata,
   output logic [31:0] nxt
);
   localparam logic [31:0] NEG_SIZE = 32'd0 - ROM_SIZE;

   if (ROM_SIZE < 32'h800 || !cfgbar_pkg::is_pow2(ROM_SIZE)) begin : g_bad
      $error("ROM size must be a power of two of at least 2 KiB");
   end

   assign nxt = ((wdata | 32'h0000_07FF) == 32'hFFFF_FFFF) ? NEG_SIZE : ROM_ADDR;
endmodule

// File: rtl/cfg_bar_space.sv
module cfg_bar_space
   import cfgbar_pkg::*;
#(
   parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE = {32'd0, 32'd0, 32'd0, 32'd0, 32'd4096, 32'd32},
   parameter logic [NUM_BARS-1:0]       BAR_IO   = 6'b000001,
   parameter logic [NUM_BARS-1:0][31:0] BAR_DEF  = {32'd0, 32'd0, 32'd0, 32'd0, 32'hFEB0_0000, 32'h0000_C001},
   parameter logic [31:0]               ROM_SIZE = 32'h0001_0000,
   parameter logic [31:0]               ROM_ADDR = 32'hFEC0_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_size,
   input  logic [7:0]  wr_off,
   input  logic [31:0] wr_data,
   input  logic [5:0]  rd_dw,
   output logic [31:0] rd_data,
   output logic        mv_valid,
   output logic [15:0] mv_old,
   output logic [15:0] mv_new
);
   localparam logic [31:0] ROM_RESET = (ROM_SIZE != 32'd0) ? ROM_ADDR : 32'd0;

   logic [SPACE_DWORDS-1:0][31:0] space_q;
   logic [NUM_BARS-1:0][31:0]     bar_nxt;
   logic [31:0]                   rom_nxt;
   logic [31:0]                   cur_dw, merged, nxt_dw;
   logic [5:0]                    idx;
   logic                          aligned, is_word, is_half, keep, mv_hit;

   assign idx    = wr_off[7:2];
   assign cur_dw = space_q[idx];

   cfg_lane_merge u_merge (
      .acc     (wr_size),
      .lane    (wr_off[1:0]),
      .data    (wr_data),
      .cur     (cur_dw),
      .aligned (aligned),
      .merged  (merged)
   );

   for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
      if (BAR_SIZE[b] == 32'd0) begin : g_absent
         assign bar_nxt[b] = 32'd0;
      end else begin : g_present
         cfg_bar_slot #(
            .SIZE    (BAR_SIZE[b]),
            .IS_IO   (BAR_IO[b]),
            .DEFAULT (BAR_DEF[b])
         ) u_slot (
            .wdata (wr_data),
            .nxt   (bar_nxt[b])
         );
      end
   end

   if (ROM_SIZE == 32'd0) begin : g_no_rom
      assign rom_nxt = 32'd0;
   end else begin : g_rom
      cfg_rom_slot #(
         .ROM_SIZE (ROM_SIZE),
         .ROM_ADDR (ROM_ADDR)
      ) u_rom (
         .wdata (wr_data),
         .nxt   (rom_nxt)
      );
   end

   always_comb begin
      is_word = wr_en && aligned && (acc_e'(wr_size) == ACC_WORD);
      is_half = wr_en && aligned && (acc_e'(wr_size) == ACC_HALF);
      keep    = wr_en && aligned;
      nxt_dw  = merged;
      mv_hit  = 1'b0;
      for (int i = 0; i < NUM_BARS; i++) begin
         if (is_word && idx == DW_BAR_FIRST + 6'(i)) begin
            nxt_dw = bar_nxt[i];
            mv_hit = BAR_IO[i] && (BAR_SIZE[i] != 32'd0);
         end
      end
      if (is_word && idx == DW_ROM) nxt_dw = rom_nxt;
      if (is_word && idx == DW_CMD) keep = 1'b0;
      if (is_half && idx >= DW_BAR_FIRST && idx <= DW_HALF_LAST) keep = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int d = 0; d < SPACE_DWORDS; d++) space_q[d] <= 32'd0;
         for (int b = 0; b < NUM_BARS; b++)
            space_q[DW_BAR_FIRST + 6'(b)] <= (BAR_SIZE[b] != 32'd0) ? BAR_DEF[b] : 32'd0;
         space_q[DW_ROM] <= ROM_RESET;
         mv_valid <= 1'b0;
         mv_old   <= 16'd0;
         mv_new   <= 16'd0;
      end else begin
         if (keep) space_q[idx] <= nxt_dw;
         mv_valid <= mv_hit;
         if (mv_hit) begin
            mv_old <= {cur_dw[15:1], 1'b0};
            mv_new <= {nxt_dw[15:1], 1'b0};
         end
      end
   end

   assign rd_data = space_q[rd_dw];
endmodule

// File: rtl/cfg_bar_space_chk.sv
module cfg_bar_space_chk #(
   parameter logic [31:0] ROM_SIZE = 32'd0,
   parameter logic [31:0] ROM_ADDR = 32'd0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [1:0]         wr_size,
   input logic [7:0]         wr_off,
   input logic               mv_valid,
   input logic [15:0]        mv_old,
   input logic [15:0]        mv_new,
   input logic [63:0][31:0]  space_q
);
   p_mv_after_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mv_valid |-> ($past(wr_en) && $past(wr_size) == 2'd2
                    && $past(wr_off) >= 8'h10 && $past(wr_off) <= 8'h27))
      else $error("mv_valid without a preceding 32-bit base register write");

   p_mv_even_bases_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mv_valid |-> (!mv_old[0] && !mv_new[0]))
      else $error("relocation bases must have bit 0 clear");

   p_misaligned_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((wr_size == 2'd1 && wr_off[0]) || (wr_size == 2'd2 && wr_off[1:0] != 2'd0)
                 || wr_size == 2'd3))
      |=> $stable(space_q))
      else $error("misaligned write changed the space");

   p_half_bar_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 2'd1 && wr_off >= 8'h10 && wr_off <= 8'h2B) |=> $stable(space_q))
      else $error("16-bit write in base register window changed the space");

   p_cmd_word_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 2'd2 && wr_off == 8'h04) |=> $stable(space_q))
      else $error("32-bit write at offset 4 changed the space");

   p_rom_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 2'd2 && wr_off == 8'h30) |=>
         ((ROM_SIZE == 32'd0) ? (space_q[12] == 32'd0)
                              : (space_q[12] == ROM_ADDR || space_q[12] == 32'd0 - ROM_SIZE)))
      else $error("ROM dword holds an unexpected value");
endmodule

bind cfg_bar_space cfg_bar_space_chk #(
   .ROM_SIZE (ROM_SIZE),
   .ROM_ADDR (ROM_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_size  (wr_size),
   .wr_off   (wr_off),
   .mv_valid (mv_valid),
   .mv_old   (mv_old),
   .mv_new   (mv_new),
   .space_q  (space_q)
);

// File: tb/cfg_bar_space_bench.sv
`timescale 1ns/1ps
module cfg_bar_space_bench;
   localparam logic [5:0][31:0] B_SIZE = {32'd0, 32'h0010_0000, 32'd256, 32'd0, 32'd4096, 32'd32};
   localparam logic [5:0]       B_IO   = 6'b001001;
   localparam logic [5:0][31:0] B_DEF  = {32'd0, 32'hE000_0008, 32'h0000_D001, 32'd0, 32'hFEB0_0000, 32'h0000_C001};
   localparam logic [31:0]      R_SIZE = 32'h0001_0000;
   localparam logic [31:0]      R_ADDR = 32'hFEC0_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_size = 2'd0;
   logic [7:0]  wr_off = 8'd0;
   logic [31:0] wr_data = 32'd0;
   logic [5:0]  rd_dw = 6'd0;
   logic [31:0] rd_data;
   logic        mv_valid;
   logic [15:0] mv_old, mv_new;

   always #4 clk = ~clk;

   cfg_bar_space #(
      .BAR_SIZE (B_SIZE), .BAR_IO (B_IO), .BAR_DEF (B_DEF),
      .ROM_SIZE (R_SIZE), .ROM_ADDR (R_ADDR)
   ) u_cfg_bar_space (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_size (wr_size),
      .wr_off (wr_off), .wr_data (wr_data), .rd_dw (rd_dw), .rd_data (rd_data),
      .mv_valid (mv_valid), .mv_old (mv_old), .mv_new (mv_new)
   );

   logic [31:0] model [64];
   bit          exp_mv;
   logic [15:0] exp_old, exp_new;
   string       cur_tag = "R1";
   int          compared = 0, mismatched = 0, cyc = 0;
   bit          done = 1'b0;

   task automatic model_reset();
      for (int d = 0; d < 64; d++) model[d] = 32'd0;
      for (int b = 0; b < 6; b++) model[4 + b] = (B_SIZE[b] != 0) ? B_DEF[b] : 32'd0;
      model[12] = R_ADDR;
      exp_mv = 1'b0;
   endtask

   task automatic model_write(input logic [1:0] sz, input logic [7:0] off, input logic [31:0] d);
      int          i;
      int          b;
      logic [31:0] mask, v;
      bit          probe;
      i = off >> 2;
      exp_mv = 1'b0;
      if (sz == 2'd0) begin
         v = model[i];
         v[8*off[1:0] +: 8] = d[7:0];
         model[i] = v;
      end else if (sz == 2'd1 && off[0] == 1'b0) begin
         if (off < 8'h10 || off > 8'h2B) begin
            v = model[i];
            v[16*off[1] +: 16] = d[15:0];
            model[i] = v;
         end
      end else if (sz == 2'd2 && off[1:0] == 2'd0) begin
         if (off >= 8'h10 && off <= 8'h27) begin
            b = i - 4;
            if (B_SIZE[b] == 0) model[i] = 32'd0;
            else begin
               mask  = B_SIZE[b] - 1;
               probe = ((d | 32'd3 | mask) == 32'hFFFF_FFFF);
               if (B_IO[b]) begin
                  v = probe ? (~mask | 32'd1) : (d | 32'd1);
                  exp_mv  = 1'b1;
                  exp_old = model[i][15:0] & 16'hFFFE;
                  exp_new = v[15:0] & 16'hFFFE;
                  model[i] = v;
               end else model[i] = probe ? ~mask : B_DEF[b];
            end
         end else if (off == 8'h30) begin
            model[i] = ((d | 32'h7FF) == 32'hFFFF_FFFF) ? (32'd0 - R_SIZE) : R_ADDR;
         end else if (off != 8'h04) model[i] = d;
      end
   endtask

   task automatic compare();
      compared++;
      if (rd_data !== model[rd_dw]) begin
         mismatched++;
         $display("FAIL %s: dword %0d actual %08h expected %08h", cur_tag, rd_dw, rd_data, model[rd_dw]);
      end
      compared++;
      if (mv_valid !== exp_mv || (exp_mv && (mv_old !== exp_old || mv_new !== exp_new))) begin
         mismatched++;
         $display("FAIL %s: move actual %0b %04h->%04h expected %0b %04h->%04h",
                  cur_tag, mv_valid, mv_old, mv_new, exp_mv, exp_old, exp_new);
      end
   endtask

   task automatic step(input bit en, input logic [1:0] sz, input logic [7:0] off,
                       input logic [31:0] d, input logic [5:0] rd, input string tag);
      @(negedge clk);
      compare();
      wr_en = en; wr_size = sz; wr_off = off; wr_data = d; rd_dw = rd;
      exp_mv = 1'b0;
      if (en) model_write(sz, off, d);
      cur_tag = tag;
   endtask

   task automatic wr(input logic [1:0] sz, input logic [7:0] off, input logic [31:0] d, input string tag);
      step(1'b1, sz, off, d, off[7:2], tag);
   endtask

   task automatic sweep(input string tag);
      for (int d = 0; d < 64; d++) step(1'b0, 2'd0, 8'd0, 32'd0, 6'(d), tag);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         mismatched++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      sweep("R1");
      // R2 plain lanes
      wr(2'd2, 8'h3C, 32'h0000_010B, "R2");
      wr(2'd0, 8'h3D, 32'h0000_00AA, "R2");
      wr(2'd1, 8'h3E, 32'h0000_1234, "R2");
      wr(2'd2, 8'h08, 32'hDEAD_BEEF, "R2");
      wr(2'd2, 8'h28, 32'h1111_2222, "R2");
      // R3 misaligned / invalid
      wr(2'd1, 8'h3D, 32'h0000_FFFF, "R3");
      wr(2'd2, 8'h3E, 32'hFFFF_FFFF, "R3");
      wr(2'd3, 8'h3C, 32'h5555_5555, "R3");
      // R4 and R7: I/O probe, then R6 rebasing back to back, two slots
      wr(2'd2, 8'h10, 32'hFFFF_FFFF, "R7");
      wr(2'd2, 8'h10, 32'h0000_E000, "R6");
      wr(2'd2, 8'h1C, 32'h0000_B000, "R6");
      wr(2'd2, 8'h1C, 32'hFFFF_FF00, "R4");
      wr(2'd2, 8'h1C, 32'h0000_A100, "R6");
      // R4 memory probes, R5 revert
      wr(2'd2, 8'h14, 32'hFFFF_FFFF, "R4");
      wr(2'd2, 8'h14, 32'hFFFF_F00F, "R4");
      wr(2'd2, 8'h14, 32'h1234_5678, "R5");
      wr(2'd2, 8'h20, 32'hFFFF_FFFF, "R4");
      wr(2'd2, 8'h20, 32'hC000_0000, "R5");
      // R8 absent slot
      wr(2'd0, 8'h18, 32'h0000_0055, "R2");
      wr(2'd2, 8'h18, 32'h0000_0001, "R8");
      wr(2'd2, 8'h24, 32'hFFFF_FFFF, "R8");
      // R9 16-bit writes in the window
      wr(2'd1, 8'h10, 32'h0000_FFFF, "R9");
      wr(2'd1, 8'h2A, 32'h0000_ABCD, "R9");
      wr(2'd1, 8'h16, 32'h0000_1357, "R9");
      // R10 ROM
      wr(2'd2, 8'h30, 32'hFFFF_F800, "R10");
      wr(2'd2, 8'h30, 32'hFFFF_F000, "R10");
      wr(2'd2, 8'h30, 32'hFFFF_FFFF, "R10");
      wr(2'd0, 8'h31, 32'h0000_0077, "R2");
      // R11 command dword
      wr(2'd2, 8'h04, 32'h0000_FFFF, "R11");
      wr(2'd0, 8'h04, 32'h0000_0007, "R11");
      wr(2'd1, 8'h06, 32'h0000_0290, "R11");
      // R12 pulse ends after one cycle
      wr(2'd2, 8'h10, 32'h0000_C000, "R12");
      step(1'b0, 2'd0, 8'd0, 32'd0, 6'd4, "R12");
      step(1'b0, 2'd0, 8'd0, 32'd0, 6'd4, "R12");
      sweep("R2");
      @(negedge clk);
      compare();
      finish_run();
   end
endmodule